// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block raises and clears the mailbox interrupts that let the two ports of a shared dual-port memory signal each other. Each port owns one mailbox word near the top of the address space. Port A owns the word just below the top, and port B owns the topmost word. When one port writes into the other port's mailbox word, the owner's active-low interrupt output goes low. The interrupt stays low until the owner reads its own mailbox word. The block watches only the control strobes, the address and a per-port hold qualifier. The memory array, the data path and the address arbitration sit outside it.

Each interrupt is kept in a two-state machine with the states `MB_IDLE` and `MB_PEND`. The machine moves from `MB_IDLE` to `MB_PEND` on the transition *post* (a qualified write by the other port). It moves from `MB_PEND` to `MB_IDLE` on the transition *collect* (a qualified read by the owner). In every other cycle it stays where it is. If a post and a collect arrive in the same cycle, the post wins. The interrupt output is low exactly while the machine is in `MB_PEND`, so the output changes one clock after the edge that samples the action.

A port whose hold input is low performs no mailbox action in that cycle. When the parameter `NARROW` is set, the top address bit takes no part in the compare. With the default 13-bit address, the two mailbox words then decode as 0xFFF and 0xFFE.

Top module: `mbx_irq_top`

## Requirements
- R1: While `rst_n` is low, and after it is released with no action, `a_irq_n` and `b_irq_n` are both 1.
- R2: A cycle with `a_cs_n`=0, `a_we_n`=0, `a_hold_n`=1 and `a_addr` all ones (0x1FFF by default) drives `b_irq_n` to 0 from the next clock.
- R3: A cycle with `b_cs_n`=0, `b_we_n`=1, `b_oe_n`=0, `b_hold_n`=1 and `b_addr` all ones, with no post to B in the same cycle, drives `b_irq_n` to 1 from the next clock.
- R4: A cycle with `b_cs_n`=0, `b_we_n`=0, `b_hold_n`=1 and `b_addr` = all ones except bit 0 cleared (0x1FFE) drives `a_irq_n` to 0 from the next clock.
- R5: A cycle with `a_cs_n`=0, `a_we_n`=1, `a_oe_n`=0, `a_hold_n`=1 and `a_addr` = 0x1FFE, with no post to A in the same cycle, drives `a_irq_n` to 1 from the next clock.
- R6: When the acting port's hold input is 0, its post or collect has no effect, and the target interrupt output keeps its value.
- R7: A port whose `*_cs_n` is 1 performs no action, whatever its other strobes and its address.
- R8: Other accesses leave both interrupts unchanged. This covers a read without output enable, a read of the other port's mailbox, a write to a port's own mailbox, and any other address.
- R9: With `NARROW`=1, address bit `ADDR_W-1` is ignored, so 0xFFF and 0xFFE act as the mailbox words, as do 0x1FFF and 0x1FFE.
- R10: When a post and a collect of the same interrupt fall in one cycle, the interrupt is (or stays) 0 afterwards.
- R11: A pending interrupt stays 0 through idle cycles and through repeated posts until a collect occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_cs_n | input | 1 | Port A chip enable, active low |
| a_we_n | input | 1 | Port A read/write: 0 write, 1 read |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_addr | input | ADDR_W | Port A address |
| a_hold_n | input | 1 | Port A hold qualifier; 0 blocks port A's actions |
| a_irq_n | output | 1 | Port A mailbox interrupt, active low |
| b_cs_n | input | 1 | Port B chip enable, active low |
| b_we_n | input | 1 | Port B read/write: 0 write, 1 read |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_addr | input | ADDR_W | Port B address |
| b_hold_n | input | 1 | Port B hold qualifier; 0 blocks port B's actions |
| b_irq_n | output | 1 | Port B mailbox interrupt, active low |

## Verification
The assertions assume that the strobes, the address and the hold inputs are synchronous to `clk` and settled at each rising edge. They also assume that both ports may act in the same cycle with no ordering between them beyond the post-wins rule. The stimulus therefore changes every input only on the falling edge, holds each access for exactly one clock, and returns both ports to an idle, unselected state between scenarios. When both ports act in one cycle, the stimulus keeps the cycle fully defined, so the expected outcome of each check follows from the requirements alone.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Mailbox interrupt state: MB_PEND means the owner has an unread message
    typedef enum logic {
        MB_IDLE = 1'b0,
        MB_PEND = 1'b1
    } mbx_state_e;

    // Qualified actions decoded from one port in one cycle
    typedef struct packed {
        logic wr_top;   // write to the topmost word
        logic wr_next;  // write to the word just below the top
        logic rd_top;   // read of the topmost word
        logic rd_next;  // read of the word just below the top
    } port_hits_t;

endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter bit NARROW = 1'b0
) (
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              hold_n,
    output port_hits_t        hits
);

    localparam int CW = NARROW ? ADDR_W - 1 : ADDR_W;

    logic [CW-1:0] cmp;
    logic          at_top;
    logic          at_next;
    logic          go_wr;
    logic          go_rd;

    generate
        if (NARROW) begin : g_narrow
            logic unused_msb;
            assign cmp        = addr[CW-1:0];
            assign unused_msb = addr[ADDR_W-1];
        end else begin : g_full
            assign cmp = addr;
        end
    endgenerate

    assign at_top  = &cmp;
    assign at_next = (&cmp[CW-1:1]) & ~cmp[0];

    // An action needs the chip selected and the port not held off
    assign go_wr = ~cs_n & ~we_n & hold_n;
    assign go_rd = ~cs_n & we_n & ~oe_n & hold_n;

    always_comb begin
        hits.wr_top  = go_wr & at_top;
        hits.wr_next = go_wr & at_next;
        hits.rd_top  = go_rd & at_top;
        hits.rd_next = go_rd & at_next;
    end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic post,
    input  logic collect,
    output logic irq_n
);

    mbx_state_e state_q;
    mbx_state_e state_d;

    // Next state: post has priority over collect
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MB_IDLE: if (post)                state_d = MB_PEND;
            MB_PEND: if (collect && !post)    state_d = MB_IDLE;
            default:                          state_d = MB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            MB_PEND: irq_n = 1'b0;
            default: irq_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter bit NARROW = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_cs_n,
    input  logic              a_we_n,
    input  logic              a_oe_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_hold_n,
    output logic              a_irq_n,
    input  logic              b_cs_n,
    input  logic              b_we_n,
    input  logic              b_oe_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_hold_n,
    output logic              b_irq_n
);

    port_hits_t hits_a;
    port_hits_t hits_b;
    logic       unused_hits;

    mbx_port_dec #(.ADDR_W(ADDR_W), .NARROW(NARROW)) u_dec_a (
        .cs_n   (a_cs_n),
        .we_n   (a_we_n),
        .oe_n   (a_oe_n),
        .addr   (a_addr),
        .hold_n (a_hold_n),
        .hits   (hits_a)
    );

    mbx_port_dec #(.ADDR_W(ADDR_W), .NARROW(NARROW)) u_dec_b (
        .cs_n   (b_cs_n),
        .we_n   (b_we_n),
        .oe_n   (b_oe_n),
        .addr   (b_addr),
        .hold_n (b_hold_n),
        .hits   (hits_b)
    );

    // Port A's mailbox is the word below the top: B posts, A collects
    mbx_flag u_flag_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .post    (hits_b.wr_next),
        .collect (hits_a.rd_next),
        .irq_n   (a_irq_n)
    );

    // Port B's mailbox is the topmost word: A posts, B collects
    mbx_flag u_flag_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .post    (hits_a.wr_top),
        .collect (hits_b.rd_top),
        .irq_n   (b_irq_n)
    );

    assign unused_hits = hits_a.wr_next ^ hits_a.rd_top ^ hits_b.wr_top ^ hits_b.rd_next;

endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
    parameter int ADDR_W = 13,
    parameter bit NARROW = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_cs_n,
    input logic              a_we_n,
    input logic              a_oe_n,
    input logic [ADDR_W-1:0] a_addr,
    input logic              a_hold_n,
    input logic              a_irq_n,
    input logic              b_cs_n,
    input logic              b_we_n,
    input logic              b_oe_n,
    input logic [ADDR_W-1:0] b_addr,
    input logic              b_hold_n,
    input logic              b_irq_n
);

    localparam int CW = NARROW ? ADDR_W - 1 : ADDR_W;
    localparam logic [CW-1:0] TOP  = {CW{1'b1}};
    localparam logic [CW-1:0] NEXT = {{(CW-1){1'b1}}, 1'b0};

    logic post_b, coll_b, post_a, coll_a;

    assign post_b = !a_cs_n && !a_we_n && a_hold_n && (a_addr[CW-1:0] == TOP);
    assign coll_b = !b_cs_n && b_we_n && !b_oe_n && b_hold_n && (b_addr[CW-1:0] == TOP);
    assign post_a = !b_cs_n && !b_we_n && b_hold_n && (b_addr[CW-1:0] == NEXT);
    assign coll_a = !a_cs_n && a_we_n && !a_oe_n && a_hold_n && (a_addr[CW-1:0] == NEXT);

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (a_irq_n && b_irq_n));

    // R2
    post_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post_b |=> !b_irq_n);

    // R3
    collect_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_b && !post_b) |=> b_irq_n);

    // R4
    post_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post_a |=> !a_irq_n);

    // R5
    collect_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_a && !post_a) |=> a_irq_n);

    // R6
    quiet_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!post_b && !coll_b) |=> $stable(b_irq_n));

    // R8
    quiet_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!post_a && !coll_a) |=> $stable(a_irq_n));

endmodule

bind mbx_irq_top mbx_irq_chk #(.ADDR_W(ADDR_W), .NARROW(NARROW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .a_cs_n(a_cs_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_addr(a_addr),
    .a_hold_n(a_hold_n), .a_irq_n(a_irq_n),
    .b_cs_n(b_cs_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_addr(b_addr),
    .b_hold_n(b_hold_n), .b_irq_n(b_irq_n)
);

// File: tb/mbx_irq_top_test.sv
module mbx_irq_top_test;

    localparam int AW = 13;
    localparam logic [AW-1:0] TOP  = 13'h1FFF;
    localparam logic [AW-1:0] NEXT = 13'h1FFE;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_cs_n, a_we_n, a_oe_n, a_hold_n;
    logic b_cs_n, b_we_n, b_oe_n, b_hold_n;
    logic [AW-1:0] a_addr, b_addr;
    logic a_irq_n, b_irq_n, na_irq_n, nb_irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mbx_irq_top #(.ADDR_W(AW), .NARROW(1'b0)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_cs_n(a_cs_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_addr(a_addr),
        .a_hold_n(a_hold_n), .a_irq_n(a_irq_n),
        .b_cs_n(b_cs_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_addr(b_addr),
        .b_hold_n(b_hold_n), .b_irq_n(b_irq_n)
    );

    mbx_irq_top #(.ADDR_W(AW), .NARROW(1'b1)) uut_narrow (
        .clk(clk), .rst_n(rst_n),
        .a_cs_n(a_cs_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_addr(a_addr),
        .a_hold_n(a_hold_n), .a_irq_n(na_irq_n),
        .b_cs_n(b_cs_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_addr(b_addr),
        .b_hold_n(b_hold_n), .b_irq_n(nb_irq_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic idle();
        a_cs_n = 1; a_we_n = 1; a_oe_n = 1; a_addr = '0; a_hold_n = 1;
        b_cs_n = 1; b_we_n = 1; b_oe_n = 1; b_addr = '0; b_hold_n = 1;
    endtask

    task automatic port_a(input logic cs, input logic we, input logic oe,
                          input logic [AW-1:0] ad, input logic hold);
        a_cs_n = cs; a_we_n = we; a_oe_n = oe; a_addr = ad; a_hold_n = hold;
    endtask

    task automatic port_b(input logic cs, input logic we, input logic oe,
                          input logic [AW-1:0] ad, input logic hold);
        b_cs_n = cs; b_we_n = we; b_oe_n = oe; b_addr = ad; b_hold_n = hold;
    endtask

    // One clock: inputs set before, outputs settled at the following falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 a_irq_n after reset", a_irq_n, 1'b1);
        check("R1 b_irq_n after reset", b_irq_n, 1'b1);
    endtask

    task automatic t_post_collect();
        port_a(0, 0, 1, TOP, 1); tick();
        check("R2 b_irq_n after A writes top", b_irq_n, 1'b0);
        check("R2 a_irq_n unaffected", a_irq_n, 1'b1);
        port_b(0, 1, 0, TOP, 1); tick();
        check("R3 b_irq_n after B reads top", b_irq_n, 1'b1);
        port_b(0, 0, 1, NEXT, 1); tick();
        check("R4 a_irq_n after B writes next", a_irq_n, 1'b0);
        port_a(0, 1, 0, NEXT, 1); tick();
        check("R5 a_irq_n after A reads next", a_irq_n, 1'b1);
    endtask

    task automatic t_hold();
        port_a(0, 0, 1, TOP, 0); tick();
        check("R6 held post to B blocked", b_irq_n, 1'b1);
        port_a(0, 0, 1, TOP, 1); tick();
        port_b(0, 1, 0, TOP, 0); tick();
        check("R6 held collect by B blocked", b_irq_n, 1'b0);
        port_b(0, 1, 0, TOP, 1); tick();
        check("R6 collect after hold lifted", b_irq_n, 1'b1);
    endtask

    task automatic t_unselected();
        port_a(1, 0, 1, TOP, 1); port_b(1, 0, 1, NEXT, 1); tick();
        check("R7 deselected A write top", b_irq_n, 1'b1);
        check("R7 deselected B write next", a_irq_n, 1'b1);
        port_b(0, 0, 1, NEXT, 1); tick();
        port_a(1, 1, 0, NEXT, 1); tick();
        check("R7 deselected A read next", a_irq_n, 1'b0);
        port_a(0, 1, 0, NEXT, 1); tick();
    endtask

    task automatic t_other();
        port_a(0, 0, 1, TOP, 1); tick();
        port_b(0, 1, 1, TOP, 1); tick();
        check("R8 B read without oe", b_irq_n, 1'b0);
        port_a(0, 1, 0, TOP, 1); tick();
        check("R8 A reads B mailbox", b_irq_n, 1'b0);
        port_a(0, 0, 1, NEXT, 1); port_b(0, 0, 1, 13'h1FFD, 1); tick();
        check("R8 own-mailbox and other writes", a_irq_n, 1'b1);
        port_b(0, 1, 0, TOP, 1); tick();
    endtask

    task automatic t_narrow();
        do_reset();
        port_a(0, 0, 1, 13'h0FFF, 1); tick();
        check("R9 narrow post at 0xFFF", nb_irq_n, 1'b0);
        check("R9 full width ignores 0xFFF", b_irq_n, 1'b1);
        port_b(0, 0, 1, 13'h0FFE, 1); tick();
        check("R9 narrow post at 0xFFE", na_irq_n, 1'b0);
        port_a(0, 1, 0, 13'h1FFE, 1); tick();
        check("R9 narrow collect at 0x1FFE", na_irq_n, 1'b1);
        do_reset();
    endtask

    task automatic t_collision();
        port_a(0, 0, 1, TOP, 1); port_b(0, 1, 0, TOP, 1); tick();
        check("R10 post and collect from idle", b_irq_n, 1'b0);
        port_a(0, 0, 1, TOP, 1); port_b(0, 1, 0, TOP, 1); tick();
        check("R10 post and collect while pending", b_irq_n, 1'b0);
        port_b(0, 1, 0, TOP, 1); tick();
    endtask

    task automatic t_sticky();
        port_b(0, 0, 1, NEXT, 1); tick();
        for (int i = 0; i < 5; i++) @(negedge clk);
        check("R11 pending through idle", a_irq_n, 1'b0);
        port_b(0, 0, 1, NEXT, 1); tick();
        check("R11 repeated post", a_irq_n, 1'b0);
        port_a(0, 1, 0, NEXT, 1); tick();
        check("R11 single collect clears", a_irq_n, 1'b1);
    endtask

    initial begin
        idle();
        t_reset();
        t_post_collect();
        t_hold();
        t_unselected();
        t_other();
        t_collision();
        t_sticky();
        t_narrow();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule